// File: doc/BRIEF.md
# Configurable Mode Event Flip-Flop Stage

This block is the storage end of an event generator. Two boolean expression results come in, computed elsewhere from a shared set of event inputs. Two event outputs go out, and they serve as hardware trigger sources. A 3-bit configuration word picks one of six behaviours. Bypass passes both expressions straight through. Set/reset, toggle, data, JK and transparent-latch modes all run a single storage bit, Q.

Every register is clocked by the bus clock. In the edge-driven modes the second expression acts as a clock, but it is never used as a real clock. The block samples it every bus cycle and treats a low-to-high change between two samples as the active edge. A force control loads a configured value into Q. Q is also brought out on its own port so that an upstream expression can use it as a feedback term. This is how a JK characteristic is built: the first expression is computed as J&~Q | ~K&Q.

Top module: `evflop_stage`

## Requirements
- R1: While rst_n is low at a clock edge, Q and the sampled copy of expr1 are cleared, so that after reset, in mode 1, evt_q_o = 0 and evt_qn_o = 1.
- R2: With cfg_mode = 0 (bypass), evt_q_o equals expr0_i and evt_qn_o equals expr1_i in the same cycle, with no register in the path. Q keeps its value, so q_fb_o does not change.
- R3: When force_init_i is high at a clock edge, Q takes cfg_init_i at that edge. This has priority over every mode, including bypass.
- R4: With cfg_mode = 1 (set/reset), expr0_i high sets Q at the next edge. Otherwise expr1_i high clears Q. Set wins when both are high, and Q holds when both are low.
- R5: expr1_i is sampled on every edge. An active edge is a cycle in which expr1_i is 1 and the previous sample is 0. The edge-driven modes (2, 3, 4) update Q only at the clock edge that ends such a cycle, and never while expr1_i stays high.
- R6: With cfg_mode = 2 (toggle), Q inverts on each active edge, whatever the value of expr0_i.
- R7: With cfg_mode = 3 (data), Q takes expr0_i on each active edge.
- R8: With cfg_mode = 4 (JK), Q takes expr0_i on each active edge. When expr0_i is formed as J&~Q | ~K&Q from q_fb_o, Q follows the JK table: hold, reset, set, toggle.
- R9: With cfg_mode = 5 (latch), Q takes expr0_i at each edge where expr1_i is high and holds while expr1_i is low.
- R10: In every non-bypass mode evt_q_o = Q and evt_qn_o = ~Q. In every mode q_fb_o = Q.
- R11: Codes 6 and 7 hold Q unchanged (force still applies) and drive the outputs as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Behaviour select (0 bypass, 1 set/reset, 2 toggle, 3 data, 4 JK, 5 latch) |
| cfg_init_i | input | 1 | Value loaded by force |
| force_init_i | input | 1 | Force Q to cfg_init_i at the next edge |
| expr0_i | input | 1 | First expression: set, data or J/K function |
| expr1_i | input | 1 | Second expression: reset or clock/enable role |
| evt_q_o | output | 1 | Event output 0 |
| evt_qn_o | output | 1 | Event output 1 |
| q_fb_o | output | 1 | Q for upstream feedback |

## Verification
The hardest case to reach is a JK update. The correct next state depends on Q itself, passed back through an expression that the bench has to rebuild every cycle. The stimulus reads q_fb_o after each step and recomputes expr0_i = J&~Q | ~K&Q for every J/K pair. It then raises expr1_i from a low sample so that exactly one active edge occurs. Holding expr1_i high for an extra cycle shows that no second update happens.

// File: rtl/evflop_pkg.sv
// Package: shared mode encoding for the event flip-flop stage.
// Assumes: the mode field is MODE_W bits wide; codes above LATCH are reserved.
package evflop_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_BYPASS = 3'd0,
        MODE_RS     = 3'd1,
        MODE_TOG    = 3'd2,
        MODE_DATA   = 3'd3,
        MODE_JK     = 3'd4,
        MODE_LATCH  = 3'd5,
        MODE_RSV6   = 3'd6,
        MODE_RSV7   = 3'd7
    } evmode_e;

    // True for the modes that update only on a detected rising edge.
    function automatic logic is_edge_mode(evmode_e m);
        return (m == MODE_TOG) || (m == MODE_DATA) || (m == MODE_JK);
    endfunction
endpackage

// File: rtl/evflop_edge_det.sv
// Module: samples the clock-role expression in the bus clock domain and
// flags a cycle in which it is high while the previous sample was low.
// Assumes: the input is already synchronous to clk.
module evflop_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] prev_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Keep a one-cycle-old copy of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_i;
    end

    // A rise is current high while the stored sample is low.
    always_comb begin
        rise_o = sig_i & ~prev_q;
    end

    assign prev_o = prev_q;

    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (prev_o == $past(sig_i)));                       // R5
endmodule

// File: rtl/evflop_state.sv
// Module: the single storage bit Q and its next-state selection per mode.
// Assumes: rise_i is a one-cycle pulse from the edge detector; force wins.
module evflop_state
    import evflop_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  evmode_e mode_i,
    input  logic    init_i,
    input  logic    force_i,
    input  logic    d0_i,
    input  logic    d1_i,
    input  logic    rise_i,
    output logic    q_o
);
    logic q_r;
    logic q_nxt;

    // Next-state choice for each mode, force taking priority.
    always_comb begin
        q_nxt = q_r;
        if (force_i) begin
            q_nxt = init_i;
        end else begin
            unique case (mode_i)
                MODE_RS:    q_nxt = d0_i ? 1'b1 : (d1_i ? 1'b0 : q_r);
                MODE_TOG:   q_nxt = rise_i ? ~q_r : q_r;
                MODE_DATA:  q_nxt = rise_i ? d0_i : q_r;
                MODE_JK:    q_nxt = rise_i ? d0_i : q_r;
                MODE_LATCH: q_nxt = d1_i ? d0_i : q_r;
                default:    q_nxt = q_r;
            endcase
        end
    end

    // Storage bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= q_nxt;
    end

    assign q_o = q_r;

    AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (q_o == $past(init_i)));                               // R3
    AST_RS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && mode_i == MODE_RS && d0_i) |=> q_o);                  // R4
    AST_RS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && mode_i == MODE_RS && !d0_i && d1_i) |=> !q_o);        // R4
    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && mode_i == MODE_TOG && rise_i) |=> (q_o != $past(q_o))); // R6
    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && is_edge_mode(mode_i) && !rise_i) |=> $stable(q_o));  // R5
    AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && (mode_i == MODE_RSV6 || mode_i == MODE_RSV7)) |=> $stable(q_o)); // R11
    AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && mode_i == MODE_BYPASS) |=> $stable(q_o));             // R2
endmodule

// File: rtl/evflop_out_mux.sv
// Module: chooses between the raw expressions (bypass) and Q / not-Q.
// Assumes: purely combinational; no register in the bypass path.
module evflop_out_mux
    import evflop_pkg::*;
(
    input  evmode_e mode_i,
    input  logic    d0_i,
    input  logic    d1_i,
    input  logic    q_i,
    output logic    out0_o,
    output logic    out1_o
);
    // Route either the expressions or the stored bit pair.
    always_comb begin
        if (mode_i == MODE_BYPASS) begin
            out0_o = d0_i;
            out1_o = d1_i;
        end else begin
            out0_o = q_i;
            out1_o = ~q_i;
        end
    end
endmodule

// File: rtl/evflop_stage.sv
// Module: top of the configurable event flip-flop stage.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module evflop_stage
    import evflop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_init_i,
    input  logic              force_init_i,
    input  logic              expr0_i,
    input  logic              expr1_i,
    output logic              evt_q_o,
    output logic              evt_qn_o,
    output logic              q_fb_o
);
    evmode_e mode;
    logic    rise;
    logic    prev1;
    logic    q;

    assign mode = evmode_e'(cfg_mode);

    evflop_edge_det #(.W(1)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (expr1_i),
        .prev_o (prev1),
        .rise_o (rise)
    );

    evflop_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .init_i  (cfg_init_i),
        .force_i (force_init_i),
        .d0_i    (expr0_i),
        .d1_i    (expr1_i),
        .rise_i  (rise),
        .q_o     (q)
    );

    evflop_out_mux u_mux (
        .mode_i (mode),
        .d0_i   (expr0_i),
        .d1_i   (expr1_i),
        .q_i    (q),
        .out0_o (evt_q_o),
        .out1_o (evt_qn_o)
    );

    assign q_fb_o = q;

    AST_COMPL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_BYPASS) |-> (evt_qn_o == ~evt_q_o));                // R10
    AST_FB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_BYPASS) |-> (q_fb_o == evt_q_o));                   // R10
    AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_init_i && mode == MODE_DATA && expr1_i && !prev1) |=> (q_fb_o == $past(expr0_i))); // R7
endmodule

// File: tb/tb_evflop_stage.sv
module tb_evflop_stage;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_mode;
    logic       cfg_init_i, force_init_i, expr0_i, expr1_i;
    logic       evt_q_o, evt_qn_o, q_fb_o;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2 clk = ~clk;

    evflop_stage dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_init_i(cfg_init_i),
        .force_init_i(force_init_i), .expr0_i(expr0_i), .expr1_i(expr1_i),
        .evt_q_o(evt_q_o), .evt_qn_o(evt_qn_o), .q_fb_o(q_fb_o)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    // Advance one clock; inputs and samples sit 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_mode = 3'd1; cfg_init_i = 1'b0; force_init_i = 1'b0;
        expr0_i = 1'b0; expr1_i = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(evt_q_o,  1'b0, "R1", "out0 after reset");
        chk(evt_qn_o, 1'b1, "R1", "out1 after reset");
        chk(q_fb_o,   1'b0, "R1", "q_fb after reset");
    endtask

    task automatic t_bypass();
        cfg_mode = 3'd0;
        for (int v = 0; v < 4; v++) begin
            expr0_i = v[0]; expr1_i = v[1];
            #1;
            chk(evt_q_o,  v[0], "R2", "bypass out0");
            chk(evt_qn_o, v[1], "R2", "bypass out1");
            step();
            chk(q_fb_o, 1'b0, "R2", "bypass holds Q");
        end
        expr0_i = 1'b0; expr1_i = 1'b0;
    endtask

    task automatic t_force();
        cfg_mode = 3'd0; cfg_init_i = 1'b1; force_init_i = 1'b1;
        step();
        chk(q_fb_o, 1'b1, "R3", "force 1 in bypass");
        cfg_mode = 3'd1; cfg_init_i = 1'b0; expr0_i = 1'b1;
        step();
        chk(q_fb_o, 1'b0, "R3", "force beats set");
        force_init_i = 1'b0; expr0_i = 1'b0;
        step();
    endtask

    task automatic t_rs();
        cfg_mode = 3'd1;
        expr0_i = 1'b1; expr1_i = 1'b0; step();
        chk(evt_q_o, 1'b1, "R4", "set");
        chk(evt_qn_o, 1'b0, "R10", "complement after set");
        expr0_i = 1'b0; expr1_i = 1'b1; step();
        chk(evt_q_o, 1'b0, "R4", "reset");
        expr0_i = 1'b1; expr1_i = 1'b1; step();
        chk(evt_q_o, 1'b1, "R4", "set priority");
        expr0_i = 1'b0; expr1_i = 1'b0; step();
        chk(evt_q_o, 1'b1, "R4", "hold");
        expr1_i = 1'b1; step();
        expr1_i = 1'b0; step();
    endtask

    task automatic t_data();
        cfg_mode = 3'd3; expr1_i = 1'b0; expr0_i = 1'b1; step();
        chk(q_fb_o, 1'b0, "R5", "no edge no capture");
        expr1_i = 1'b1; step();
        chk(q_fb_o, 1'b1, "R7", "capture on rise");
        expr0_i = 1'b0; step();
        chk(q_fb_o, 1'b1, "R5", "held high no capture");
        expr1_i = 1'b0; step();
        chk(q_fb_o, 1'b1, "R5", "fall no capture");
        expr1_i = 1'b1; step();
        chk(q_fb_o, 1'b0, "R7", "capture zero");
        expr1_i = 1'b0; step();
    endtask

    task automatic t_toggle();
        logic exp_q;
        cfg_mode = 3'd2; expr1_i = 1'b0; step();
        exp_q = q_fb_o;
        for (int i = 0; i < 3; i++) begin
            expr0_i = i[0];
            expr1_i = 1'b1; step();
            exp_q = ~exp_q;
            chk(q_fb_o, exp_q, "R6", "toggle on rise");
            step();
            chk(q_fb_o, exp_q, "R6", "no toggle while high");
            expr1_i = 1'b0; step();
        end
    endtask

    task automatic t_jk();
        logic exp_q;
        cfg_mode = 3'd4; expr1_i = 1'b0; step();
        for (int v = 0; v < 8; v++) begin
            logic j, k;
            j = v[0]; k = v[1];
            expr0_i = (j & ~q_fb_o) | (~k & q_fb_o);
            exp_q = j & k ? ~q_fb_o : (j ? 1'b1 : (k ? 1'b0 : q_fb_o));
            expr1_i = 1'b1; step();
            chk(q_fb_o, exp_q, "R8", "JK next state");
            expr0_i = (j & ~q_fb_o) | (~k & q_fb_o);
            step();
            chk(q_fb_o, exp_q, "R8", "JK stable while clock high");
            expr1_i = 1'b0; step();
        end
    endtask

    task automatic t_latch();
        cfg_mode = 3'd5; expr1_i = 1'b1;
        expr0_i = 1'b1; step();
        chk(q_fb_o, 1'b1, "R9", "transparent 1");
        expr0_i = 1'b0; step();
        chk(q_fb_o, 1'b0, "R9", "transparent 0");
        expr1_i = 1'b0; expr0_i = 1'b1; step();
        chk(q_fb_o, 1'b0, "R9", "opaque hold");
        step();
        chk(evt_qn_o, 1'b1, "R10", "complement in latch");
    endtask

    task automatic t_reserved();
        cfg_init_i = 1'b1; force_init_i = 1'b1; step();
        force_init_i = 1'b0;
        for (int m = 6; m < 8; m++) begin
            cfg_mode = 3'(m);
            expr0_i = 1'b0; expr1_i = 1'b1; step();
            chk(q_fb_o, 1'b1, "R11", "reserved hold");
            chk(evt_qn_o, 1'b0, "R11", "reserved complement");
            expr1_i = 1'b0; step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass();
        t_force();
        t_rs();
        t_data();
        t_toggle();
        t_jk();
        t_latch();
        t_reserved();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule